// File: doc/BRIEF.md
# Acknowledgement Frame Assembler

This block builds the short acknowledgement frame that a low-rate personal area network radio sends back after it receives a frame. It puts the frame out one octet at a time toward the next transmit stage. A pulse on `start_i` while the block is idle captures a sequence number and a frame-pending flag. The block then sends a fixed physical-layer header, a two-octet frame control field, the sequence number and a two-octet CRC-16 check value, in that order. The frame is 11 octets (88 bits) in all.

One binary-coded 5-bit state register steps through every field. Its states are `ST_IDLE`, `ST_PREAMBLE`, `ST_SFD`, `ST_PHR_LEN`, `ST_FC_LO`, `ST_FC_HI`, `ST_SEQ`, `ST_FCS_LO` and `ST_FCS_HI`. The transitions are:

- `ST_IDLE` to `ST_PREAMBLE` on start.
- `ST_PREAMBLE` stays put until its octet counter reaches `PREAMBLE_LEN-1` on an accepted octet, then goes to `ST_SFD`.
- Each later state moves to the next one on an accepted octet.
- `ST_FCS_HI` returns to `ST_IDLE` on an accepted octet.

An octet is accepted when `out_valid_o` and `out_ready_i` are both high. A CRC engine beside the state machine folds the three MAC octets in as they are accepted, so the check value is ready when the state machine reaches the check-value states.

Top module: `ack_frame_assembler`

## Requirements
- R1: After reset the block is idle, with `out_valid_o`, `out_last_o` and `busy_o` low.
- R2: A start seen while idle produces exactly 11 octets, in this order:
  - four preamble octets of 0x00
  - the delimiter 0xA7
  - the length 0x05
  - frame control low, then frame control high
  - the sequence number
  - check value low octet, then check value high octet
- R3: Frame control low is 0x02, which puts the acknowledgement type code 3'b010 in bits [2:0]. Bit 4 of that octet is set exactly when frame pending was captured. Frame control high is 0x00.
- R4: The sequence octet equals `seq_num_i` as sampled in the cycle the start was taken.
- R5: The check value is the CRC-16 of the three MAC octets (frame control low, frame control high, sequence). It uses polynomial 0x8005 (x^16+x^15+x^2+1), initial value 0, and takes each octet most significant bit first. Its bits [7:0] are sent first and bits [15:8] last.
- R6: The block moves to the next octet only on a cycle where valid and ready are both high. While it is stalled, `out_valid_o` and `out_data_o` hold their values.
- R7: `busy_o` and `out_valid_o` rise in the cycle after the start is taken. They stay high until the final octet is accepted, and drop in the cycle after that.
- R8: A start seen while a frame is in progress is ignored. The octets of the current frame, including the captured sequence number and pending flag, do not change.
- R9: `out_last_o` is high exactly while the final check-value octet is offered.
- R10: A start on the same edge that accepts the final octet is ignored, and the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to send one acknowledgement frame |
| seq_num_i | input | 8 | Sequence number to place in the frame |
| frame_pend_i | input | 1 | Frame-pending flag for the frame control field |
| out_ready_i | input | 1 | Downstream can take an octet this cycle |
| out_valid_o | output | 1 | An octet is offered on `out_data_o` |
| out_data_o | output | 8 | Current frame octet |
| out_last_o | output | 1 | The offered octet is the last of the frame |
| busy_o | output | 1 | A frame is in progress |

## Verification
The hardest case to reach from the ports is a start request that lands on the exact edge where the final check-value octet is accepted. A close second is a start request arriving during a stall in the middle of the frame, carrying a different sequence number and pending flag.

The stimulus holds `start_i` high on every cycle with new field values. It also runs `out_ready_i` through always-high, alternating and random patterns, so both coincidences occur many times. A queue-based model, updated every cycle, predicts each octet and the flags to compare against.

// File: rtl/ack_frame_pkg.sv
package ack_frame_pkg;

    typedef enum logic [4:0] {
        ST_IDLE     = 5'd0,
        ST_PREAMBLE = 5'd1,
        ST_SFD      = 5'd2,
        ST_PHR_LEN  = 5'd3,
        ST_FC_LO    = 5'd4,
        ST_FC_HI    = 5'd5,
        ST_SEQ      = 5'd6,
        ST_FCS_LO   = 5'd7,
        ST_FCS_HI   = 5'd8
    } afa_state_e;

    localparam logic [2:0] FTYPE_ACK   = 3'b010;
    localparam int         FPEND_BIT   = 4;
    localparam int         FC_OCTETS   = 2;
    localparam int         SEQ_OCTETS  = 1;
    localparam int         FCS_OCTETS  = 2;

endpackage

// File: rtl/ack_fcs16.sv
module ack_fcs16 #(
    parameter int          WIDTH = 16,
    parameter logic [15:0] POLY  = 16'h8005,
    parameter logic [15:0] INIT  = 16'h0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             en_i,
    input  logic [7:0]       data_i,
    output logic [WIDTH-1:0] crc_o
);

    logic [WIDTH-1:0] crc_q;
    logic [WIDTH-1:0] crc_next;

    // Fold one octet in, most significant bit first.
    always_comb begin
        logic fb;
        crc_next = crc_q;
        for (int i = 7; i >= 0; i--) begin
            fb       = crc_next[WIDTH-1] ^ data_i[i];
            crc_next = {crc_next[WIDTH-2:0], 1'b0};
            if (fb) begin
                crc_next = crc_next ^ POLY[WIDTH-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= INIT[WIDTH-1:0];
        end else if (clear_i) begin
            crc_q <= INIT[WIDTH-1:0];
        end else if (en_i) begin
            crc_q <= crc_next;
        end
    end

    assign crc_o = crc_q;

endmodule

// File: rtl/ack_frame_ctrl.sv
module ack_frame_ctrl
    import ack_frame_pkg::*;
#(
    parameter int PREAMBLE_LEN = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       accept_i,
    output afa_state_e state_o
);

    localparam int PCW = (PREAMBLE_LEN < 2) ? 1 : $clog2(PREAMBLE_LEN);

    afa_state_e     state_q;
    afa_state_e     state_d;
    logic [PCW-1:0] pre_cnt_q;
    logic           pre_done;

    assign pre_done = (pre_cnt_q == PCW'(PREAMBLE_LEN - 1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Preamble octet counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt_q <= '0;
        end else if (state_q != ST_PREAMBLE) begin
            pre_cnt_q <= '0;
        end else if (accept_i) begin
            pre_cnt_q <= pre_cnt_q + 1'b1;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start_i)              state_d = ST_PREAMBLE;
            ST_PREAMBLE: if (accept_i && pre_done) state_d = ST_SFD;
            ST_SFD:      if (accept_i)             state_d = ST_PHR_LEN;
            ST_PHR_LEN:  if (accept_i)             state_d = ST_FC_LO;
            ST_FC_LO:    if (accept_i)             state_d = ST_FC_HI;
            ST_FC_HI:    if (accept_i)             state_d = ST_SEQ;
            ST_SEQ:      if (accept_i)             state_d = ST_FCS_LO;
            ST_FCS_LO:   if (accept_i)             state_d = ST_FCS_HI;
            ST_FCS_HI:   if (accept_i)             state_d = ST_IDLE;
            default:                               state_d = ST_IDLE;
        endcase
    end

    assign state_o = state_q;

    assert_idle_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start_i) |=> (state_q == ST_PREAMBLE));

    assert_stall_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && !accept_i) |=> (state_q == $past(state_q)));

    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && state_q != ST_FCS_HI && start_i) |=> (state_q != ST_IDLE));

endmodule

// File: rtl/ack_frame_assembler.sv
module ack_frame_assembler
    import ack_frame_pkg::*;
#(
    parameter int         PREAMBLE_LEN = 4,
    parameter logic [7:0] SFD_OCTET    = 8'hA7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [7:0] seq_num_i,
    input  logic       frame_pend_i,
    input  logic       out_ready_i,
    output logic       out_valid_o,
    output logic [7:0] out_data_o,
    output logic       out_last_o,
    output logic       busy_o
);

    localparam int         MAC_LEN   = FC_OCTETS + SEQ_OCTETS + FCS_OCTETS;
    localparam logic [7:0] LEN_OCTET = 8'(MAC_LEN);

    afa_state_e  state;
    logic        accept;
    logic        take_start;
    logic [7:0]  seq_q;
    logic        pend_q;
    logic        crc_en;
    logic [15:0] fcs;
    logic [7:0]  fc_lo;

    assign take_start = (state == ST_IDLE) && start_i;
    assign accept     = out_valid_o && out_ready_i;

    // Capture frame fields on an accepted start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q  <= '0;
            pend_q <= 1'b0;
        end else if (take_start) begin
            seq_q  <= seq_num_i;
            pend_q <= frame_pend_i;
        end
    end

    ack_frame_ctrl #(
        .PREAMBLE_LEN (PREAMBLE_LEN)
    ) i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .accept_i (accept),
        .state_o  (state)
    );

    assign crc_en = accept && (state == ST_FC_LO || state == ST_FC_HI || state == ST_SEQ);

    ack_fcs16 #(
        .WIDTH (16),
        .POLY  (16'h8005),
        .INIT  (16'h0000)
    ) i_fcs (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (state == ST_IDLE),
        .en_i    (crc_en),
        .data_i  (out_data_o),
        .crc_o   (fcs)
    );

    always_comb begin
        fc_lo            = '0;
        fc_lo[2:0]       = FTYPE_ACK;
        fc_lo[FPEND_BIT] = pend_q;
    end

    // Output decode
    always_comb begin
        out_valid_o = 1'b1;
        out_last_o  = 1'b0;
        out_data_o  = 8'h00;
        unique case (state)
            ST_IDLE:     out_valid_o = 1'b0;
            ST_PREAMBLE: out_data_o  = 8'h00;
            ST_SFD:      out_data_o  = SFD_OCTET;
            ST_PHR_LEN:  out_data_o  = LEN_OCTET;
            ST_FC_LO:    out_data_o  = fc_lo;
            ST_FC_HI:    out_data_o  = 8'h00;
            ST_SEQ:      out_data_o  = seq_q;
            ST_FCS_LO:   out_data_o  = fcs[7:0];
            ST_FCS_HI: begin
                out_data_o = fcs[15:8];
                out_last_o = 1'b1;
            end
            default:     out_valid_o = 1'b0;
        endcase
    end

    assign busy_o = (state != ST_IDLE);

    assert_data_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

    assert_last_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_last_o && out_ready_i) |=> !busy_o);

    assert_late_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_last_o && out_ready_i && start_i) |=> !out_valid_o);

    assert_fcs_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FCS_LO || state == ST_FCS_HI) |=> (!busy_o || $stable(fcs)));

endmodule

// File: tb/test_ack_frame_assembler.sv
module test_ack_frame_assembler;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] seq_num_i = 8'h00;
    logic       frame_pend_i = 1'b0;
    logic       out_ready_i = 1'b0;
    logic       out_valid_o;
    logic [7:0] out_data_o;
    logic       out_last_o;
    logic       busy_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [7:0] q[$];

    always #5 clk = ~clk;

    ack_frame_assembler i_ack_frame_assembler (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .seq_num_i    (seq_num_i),
        .frame_pend_i (frame_pend_i),
        .out_ready_i  (out_ready_i),
        .out_valid_o  (out_valid_o),
        .out_data_o   (out_data_o),
        .out_last_o   (out_last_o),
        .busy_o       (busy_o)
    );

    // Remainder of message * x^16 divided by x^16+x^15+x^2+1 (R5)
    function automatic logic [15:0] ref_fcs(input logic [23:0] msg);
        logic [39:0] r;
        r = {msg, 16'h0000};
        for (int i = 39; i >= 16; i--) begin
            if (r[i]) r[i -: 17] = r[i -: 17] ^ 17'h18005;
        end
        return r[15:0];
    endfunction

    task automatic push_frame(input logic [7:0] sq, input logic pd);
        logic [7:0]  fl;
        logic [15:0] c;
        fl = 8'h02 | (pd ? 8'h10 : 8'h00);
        c  = ref_fcs({fl, 8'h00, sq});
        for (int k = 0; k < 4; k++) q.push_back(8'h00);
        q.push_back(8'hA7);
        q.push_back(8'h05);
        q.push_back(fl);
        q.push_back(8'h00);
        q.push_back(sq);
        q.push_back(c[7:0]);
        q.push_back(c[15:8]);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d actual %h expected %h", req, cyc, act, exp);
        end
    endtask

    function automatic string tag_for(input int idx);
        if (idx < 6)  return "R2";
        if (idx < 8)  return "R3";
        if (idx == 8) return "R4";
        return "R5";
    endfunction

    task automatic step(input logic st, input logic rdy);
        int idx;
        @(negedge clk);
        // compare against model; stalls (R6) and ignored starts (R8, R10) surface here
        chk("R7 valid", {7'd0, out_valid_o}, {7'd0, q.size() != 0});
        chk("R7 busy",  {7'd0, busy_o},      {7'd0, q.size() != 0});
        if (q.size() != 0) begin
            idx = 11 - q.size();
            chk(tag_for(idx), out_data_o, q[0]);
            chk("R9 last", {7'd0, out_last_o}, {7'd0, q.size() == 1});
        end
        start_i      = st;
        seq_num_i    = 8'($urandom);
        frame_pend_i = 1'($urandom);
        out_ready_i  = rdy;
        if (q.size() != 0) begin
            if (rdy) void'(q.pop_front());
        end else if (st) begin
            push_frame(seq_num_i, frame_pend_i);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 valid", {7'd0, out_valid_o}, 8'd0);
        chk("R1 busy",  {7'd0, busy_o},      8'd0);
        chk("R1 last",  {7'd0, out_last_o},  8'd0);
        rst_n = 1'b1;
        repeat (2) step(1'b0, 1'b1);
        chk("R1 idle after release", {7'd0, busy_o}, 8'd0);
        // Ready always high, start held: covers R10 on every frame end
        for (int n = 0; n < 300; n++) step(1'b1, 1'b1);
        // Alternating ready, start held: stalls (R6) and start while busy (R8)
        for (int n = 0; n < 500; n++) step(1'b1, n[0]);
        // Random ready and start
        for (int n = 0; n < 2000; n++) step(($urandom % 3) == 0, ($urandom % 5) < 3);
        // Ready low for long stretches
        for (int n = 0; n < 400; n++) step(1'b1, (n % 7) == 0);
        for (int n = 0; n < 40; n++) step(1'b0, 1'b1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule